// File: doc/BRIEF.md
# Attribute-Checked Thermal Limit Register Block

This block is an APB completer that holds four 16-bit thermal-shutdown limit values and protects them with an access check. The check runs on every transfer before the transfer can touch a register. It uses three inputs: the transfer's protection bits, a fixed 3-bit hardware identity that the requester drives on a sideband input, and a policy table. The policy gives each register a read-permission mask and a write-permission mask, each with one bit per identity. The policy and the register reset values are parameters, so they cannot be changed while the chip runs.

In the setup phase the block samples the address, direction, protection bits and identity. It makes its decision during the access phase and always completes that phase without wait states. An allowed read returns the register value. An allowed write stores the low 16 bits of the write data. A denied transfer raises PSLVERR, returns zero read data and leaves every register unchanged. A denial also sets a sticky violation flag and records the identity of the requester that was refused. A testbench can observe both.

Top module: `apb_limit_guard`

## Requirements
- R1: On reset the four limits take their default values: 0x0050 at offset 0x0, 0x0064 at 0x4, 0x0069 at 0x8 and 0x0078 at 0xC. The violation flag and the recorded identity both clear to 0.
- R2: PREADY is 1 in every access phase (PSEL=1, PENABLE=1) and 0 in the setup phase, so every transfer completes without wait states.
- R3: A read is allowed only when the bit selected by the requester identity is set in that register's read mask. The default read masks are 0xFF for 0x0, 0x0F for 0x4, 0x03 for 0x8 and 0x01 for 0xC. An allowed read returns the value in PRDATA[15:0] with PRDATA[31:16]=0 and PSLVERR=0.
- R4: A write is allowed only when three conditions hold: the identity bit is set in the register's write mask, PPROT[0]=1 (privileged), and PPROT[1]=0 (secure). The default write masks are 0x03 for 0x0, 0x03 for 0x4, 0x01 for 0x8 and 0x01 for 0xC. An allowed write stores PWDATA[15:0] and ignores PWDATA[31:16].
- R5: Any transfer with PPROT[2]=1 (instruction fetch) is denied, whether it is a read or a write.
- R6: Any address other than 0x0, 0x4, 0x8 or 0xC is denied. This includes unaligned addresses and addresses above 0xC.
- R7: A denied transfer gives PSLVERR=1 and PRDATA=0 in its access phase and leaves all four limit values unchanged.
- R8: The identity, protection bits, address and direction are the values sampled in the setup phase. Changes on the identity or protection inputs during the access phase do not alter the decision.
- R9: The violation flag sets on the first denied transfer and stays set until reset. The recorded identity always holds the identity of the most recent denied transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset; released internally after two clock edges |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data; the low 16 bits are stored |
| pprot | input | 3 | Bit 0 privileged, bit 1 non-secure, bit 2 instruction |
| req_id | input | 3 | Fixed hardware identity of the requester, sampled in the setup phase |
| prdata | output | 32 | Read data; zero unless the access is an allowed read |
| pready | output | 1 | Transfer completion |
| pslverr | output | 1 | Access denied |
| viol_flag | output | 1 | Sticky record that some transfer was denied |
| viol_id | output | 3 | Identity of the most recent denied transfer |

## Verification
A denied write has two effects on the same clock edge: the write to the limit register must be suppressed, and the violation record must be updated. The bench provokes this with writes that carry an unprivileged, non-secure, masked-out or instruction-type attribute. Each such write presents new data on PWDATA. The bench judges the outcome by reading the same register back to confirm the old value is still there, and by checking that the recorded identity has moved to the refused requester. The second case of overlapping functions is the sticky flag: it is already set when a later denial overwrites the recorded identity in the same edge. The bench checks that the flag stays set and the identity changes.

// File: rtl/apb_guard_pkg.sv
package apb_guard_pkg;

  typedef struct packed {
    logic instr;   // bit 2: instruction fetch
    logic nonsec;  // bit 1: non-secure
    logic priv;    // bit 0: privileged
  } prot_t;

  function automatic logic is_secure_priv(prot_t p);
    return p.priv && !p.nonsec;
  endfunction

endpackage

// File: rtl/guard_capture.sv
module guard_capture
  import apb_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              pwrite,
  input  logic [2:0]        pprot,
  input  logic [ID_W-1:0]   req_id,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              cap_wr,
  output prot_t             cap_prot,
  output logic [ID_W-1:0]   cap_id
);

  logic [ADDR_W-1:0] addr_n;
  logic              wr_n;
  prot_t             prot_n;
  logic [ID_W-1:0]   id_n;

  always_comb begin
    addr_n = cap_addr;
    wr_n   = cap_wr;
    prot_n = cap_prot;
    id_n   = cap_id;
    if (setup) begin
      addr_n = paddr;
      wr_n   = pwrite;
      prot_n = prot_t'(pprot);
      id_n   = req_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_wr   <= 1'b0;
      cap_prot <= '0;
      cap_id   <= '0;
    end else begin
      cap_addr <= addr_n;
      cap_wr   <= wr_n;
      cap_prot <= prot_n;
      cap_id   <= id_n;
    end
  end

  AST_ID_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
    setup |=> (cap_id == $past(req_id) && cap_prot == prot_t'($past(pprot)))); // R8

endmodule

// File: rtl/guard_policy.sv
module guard_policy
  import apb_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NREG   = 4,
  parameter int ID_W   = 3,
  parameter logic [NREG*(1<<ID_W)-1:0] RD_POLICY = '0,
  parameter logic [NREG*(1<<ID_W)-1:0] WR_POLICY = '0
) (
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              cap_wr,
  input  prot_t             cap_prot,
  input  logic [ID_W-1:0]   cap_id,
  output logic [NREG-1:0]   hit,
  output logic              allow
);

  localparam int NID    = 1 << ID_W;
  localparam int WORD_W = ADDR_W - 2;

  logic              aligned;
  logic [WORD_W-1:0] word;
  logic [NREG-1:0]   perm;

  assign aligned = (cap_addr[1:0] == 2'b00);
  assign word    = cap_addr[ADDR_W-1:2];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [NID-1:0] RD_ROW = RD_POLICY[g*NID +: NID];
    localparam logic [NID-1:0] WR_ROW = WR_POLICY[g*NID +: NID];
    assign hit[g]  = aligned && (word == WORD_W'(g));
    assign perm[g] = cap_wr ? (WR_ROW[cap_id] && is_secure_priv(cap_prot))
                            : RD_ROW[cap_id];
  end

  assign allow = (|(hit & perm)) && !cap_prot.instr;

endmodule

// File: rtl/limit_regfile.sv
module limit_regfile #(
  parameter int NREG  = 4,
  parameter int REG_W = 16,
  parameter logic [NREG*REG_W-1:0] RST_VALS = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREG-1:0]       wr_sel,
  input  logic [REG_W-1:0]      wr_data,
  output logic [NREG*REG_W-1:0] q
);

  for (genvar g = 0; g < NREG; g++) begin : g_lim
    logic [REG_W-1:0] val_q;
    logic [REG_W-1:0] val_n;

    always_comb begin
      val_n = val_q;
      if (wr_sel[g]) val_n = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= RST_VALS[g*REG_W +: REG_W];
      else        val_q <= val_n;
    end

    assign q[g*REG_W +: REG_W] = val_q;
  end

endmodule

// File: rtl/apb_limit_guard.sv
module apb_limit_guard #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 16,
  parameter int NREG   = 4,
  parameter int ID_W   = 3,
  parameter logic [NREG*(1<<ID_W)-1:0] RD_POLICY = 32'h01_03_0F_FF,
  parameter logic [NREG*(1<<ID_W)-1:0] WR_POLICY = 32'h01_01_03_03,
  parameter logic [NREG*REG_W-1:0]     RST_VALS  = 64'h0078_0069_0064_0050
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [2:0]        pprot,
  input  logic [ID_W-1:0]   req_id,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              viol_flag,
  output logic [ID_W-1:0]   viol_id
);

  import apb_guard_pkg::*;

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic setup;
  logic access;
  assign setup  = psel && !penable;
  assign access = psel && penable;

  logic [ADDR_W-1:0] cap_addr;
  logic              cap_wr;
  prot_t             cap_prot;
  logic [ID_W-1:0]   cap_id;

  guard_capture #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .setup    (setup),
    .paddr    (paddr),
    .pwrite   (pwrite),
    .pprot    (pprot),
    .req_id   (req_id),
    .cap_addr (cap_addr),
    .cap_wr   (cap_wr),
    .cap_prot (cap_prot),
    .cap_id   (cap_id)
  );

  logic [NREG-1:0] hit;
  logic            allow;

  guard_policy #(
    .ADDR_W(ADDR_W), .NREG(NREG), .ID_W(ID_W),
    .RD_POLICY(RD_POLICY), .WR_POLICY(WR_POLICY)
  ) u_pol (
    .cap_addr (cap_addr),
    .cap_wr   (cap_wr),
    .cap_prot (cap_prot),
    .cap_id   (cap_id),
    .hit      (hit),
    .allow    (allow)
  );

  logic                  wr_go;
  logic [NREG-1:0]       wr_sel;
  logic [NREG*REG_W-1:0] reg_vals;

  assign wr_go  = access && cap_wr && allow;
  assign wr_sel = hit & {NREG{wr_go}};

  limit_regfile #(.NREG(NREG), .REG_W(REG_W), .RST_VALS(RST_VALS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_sel  (wr_sel),
    .wr_data (pwdata[REG_W-1:0]),
    .q       (reg_vals)
  );

  logic unused_pwdata_hi;
  assign unused_pwdata_hi = ^pwdata[DATA_W-1:REG_W];

  // read path: value released only for an allowed read
  logic [REG_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) rd_val = rd_val | reg_vals[i*REG_W +: REG_W];
    end
  end

  logic rd_go;
  assign rd_go   = access && !cap_wr && allow;
  assign prdata  = rd_go ? {{(DATA_W-REG_W){1'b0}}, rd_val} : '0;
  assign pready  = access;
  assign pslverr = access && !allow;

  // violation record
  logic            flag_n;
  logic [ID_W-1:0] vid_n;

  always_comb begin
    flag_n = viol_flag;
    vid_n  = viol_id;
    if (access && !allow) begin
      flag_n = 1'b1;
      vid_n  = cap_id;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      viol_flag <= 1'b0;
      viol_id   <= '0;
    end else begin
      viol_flag <= flag_n;
      viol_id   <= vid_n;
    end
  end

  AST_SETUP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (psel && !penable) |-> !pready); // R2
  AST_WR_NEEDS_SECURE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (access && cap_wr && !pslverr) |-> (cap_prot.priv && !cap_prot.nonsec)); // R4
  AST_INSTR_DENIED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (access && cap_prot.instr) |-> pslverr); // R5
  AST_BAD_ALIGN_DENIED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (access && cap_addr[1:0] != 2'b00) |-> pslverr); // R6
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pslverr |-> (prdata == '0)); // R7
  AST_DENY_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pslverr |=> $stable(reg_vals)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    viol_flag |=> viol_flag); // R9

endmodule

// File: tb/sim_apb_limit_guard.sv
`timescale 1ns/100ps
module sim_apb_limit_guard;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata;
  logic [2:0]  pprot;
  logic [2:0]  req_id;
  logic [31:0] prdata;
  logic        pready, pslverr, viol_flag;
  logic [2:0]  viol_id;

  always #2.5 clk = ~clk;

  apb_limit_guard u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pprot(pprot),
    .req_id(req_id), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .viol_flag(viol_flag), .viol_id(viol_id)
  );

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // prot encoding: bit0 privileged, bit1 non-secure, bit2 instruction
  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [2:0]  prot;
    logic [2:0]  id;
    logic        err;
    logic [31:0] rdata;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 32'h0,        3'b000, 3'd5, 1'b0, 32'h0050, 8'd3}, // R3 R1
    '{1'b0, 8'h04, 32'h0,        3'b010, 3'd3, 1'b0, 32'h0064, 8'd3}, // R3 R1
    '{1'b0, 8'h04, 32'h0,        3'b000, 3'd4, 1'b1, 32'h0,    8'd3}, // R3 mask
    '{1'b0, 8'h0C, 32'h0,        3'b000, 3'd0, 1'b0, 32'h0078, 8'd3}, // R3 R1
    '{1'b0, 8'h0C, 32'h0,        3'b000, 3'd1, 1'b1, 32'h0,    8'd3}, // R3 mask
    '{1'b1, 8'h08, 32'h006E,     3'b001, 3'd0, 1'b0, 32'h0,    8'd4}, // R4
    '{1'b0, 8'h08, 32'h0,        3'b000, 3'd1, 1'b0, 32'h006E, 8'd4}, // R4 readback
    '{1'b1, 8'h00, 32'h1234,     3'b001, 3'd1, 1'b0, 32'h0,    8'd4}, // R4
    '{1'b0, 8'h00, 32'h0,        3'b000, 3'd7, 1'b0, 32'h1234, 8'd4}, // R4 readback
    '{1'b1, 8'h00, 32'hAAAA,     3'b000, 3'd1, 1'b1, 32'h0,    8'd4}, // R4 unprivileged
    '{1'b1, 8'h00, 32'hBBBB,     3'b011, 3'd1, 1'b1, 32'h0,    8'd4}, // R4 non-secure
    '{1'b1, 8'h00, 32'hCCCC,     3'b001, 3'd2, 1'b1, 32'h0,    8'd4}, // R4 mask
    '{1'b0, 8'h00, 32'h0,        3'b000, 3'd0, 1'b0, 32'h1234, 8'd7}, // R7 unchanged
    '{1'b0, 8'h00, 32'h0,        3'b100, 3'd0, 1'b1, 32'h0,    8'd5}, // R5 read
    '{1'b1, 8'h04, 32'h5555,     3'b101, 3'd0, 1'b1, 32'h0,    8'd5}, // R5 write
    '{1'b0, 8'h04, 32'h0,        3'b000, 3'd0, 1'b0, 32'h0064, 8'd7}, // R7 unchanged
    '{1'b0, 8'h10, 32'h0,        3'b000, 3'd0, 1'b1, 32'h0,    8'd6}, // R6 beyond
    '{1'b0, 8'h02, 32'h0,        3'b000, 3'd0, 1'b1, 32'h0,    8'd6}, // R6 unaligned
    '{1'b1, 8'h14, 32'h1,        3'b001, 3'd6, 1'b1, 32'h0,    8'd6}, // R6 write
    '{1'b1, 8'h0C, 32'h00FF0099, 3'b001, 3'd0, 1'b0, 32'h0,    8'd4}, // R4 upper ignored
    '{1'b0, 8'h0C, 32'h0,        3'b000, 3'd0, 1'b0, 32'h0099, 8'd3}  // R3 upper zero
  };

  logic [31:0] r_data;
  logic        r_err, r_rdy, r_setup_rdy;

  // called at a falling edge; returns at a falling edge
  task automatic xfer(input logic wr, input logic [7:0] addr, input logic [31:0] data,
                      input logic [2:0] prot, input logic [2:0] id,
                      input bit swap, input logic [2:0] sw_prot, input logic [2:0] sw_id);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr;
    pwdata = data; pprot = prot; req_id = id;
    #1 r_setup_rdy = pready;
    @(negedge clk);
    penable = 1'b1;
    if (swap) begin pprot = sw_prot; req_id = sw_id; end
    #1;
    r_data = prdata; r_err = pslverr; r_rdy = pready;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; pprot = '0; req_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state of the violation record, R2 idle
    chk(viol_flag == 1'b0, "R1 flag", {31'b0, viol_flag}, 32'h0);
    chk(viol_id == 3'd0, "R1 id", {29'b0, viol_id}, 32'h0);
    chk(pready == 1'b0, "R2 idle", {31'b0, pready}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      xfer(VECS[v].wr, VECS[v].addr, VECS[v].data, VECS[v].prot, VECS[v].id,
           1'b0, 3'b0, 3'd0);
      chk(r_rdy == 1'b1 && r_setup_rdy == 1'b0, $sformatf("R2 vec%0d", v),
          {30'b0, r_setup_rdy, r_rdy}, 32'h1);
      chk(r_err == VECS[v].err, $sformatf("R%0d vec%0d err", VECS[v].req, v),
          {31'b0, r_err}, {31'b0, VECS[v].err});
      chk(r_data == VECS[v].rdata, $sformatf("R%0d vec%0d data", VECS[v].req, v),
          r_data, VECS[v].rdata);
    end

    // R9 flag set; last denial came from identity 6, later allowed accesses keep it
    chk(viol_flag == 1'b1, "R9 flag", {31'b0, viol_flag}, 32'h1);
    chk(viol_id == 3'd6, "R9 id", {29'b0, viol_id}, 32'h6);

    // R8 allowed in setup, switched to forbidden values during access
    xfer(1'b0, 8'h0C, 32'h0, 3'b000, 3'd0, 1'b1, 3'b100, 3'd3);
    chk(r_err == 1'b0, "R8 keep allow", {31'b0, r_err}, 32'h0);
    chk(r_data == 32'h0099, "R8 data", r_data, 32'h0099);

    // R8 denied in setup, switched to allowed identity during access
    xfer(1'b0, 8'h0C, 32'h0, 3'b000, 3'd1, 1'b1, 3'b000, 3'd0);
    chk(r_err == 1'b1, "R8 keep deny", {31'b0, r_err}, 32'h1);
    chk(viol_id == 3'd1, "R9 id overwrite", {29'b0, viol_id}, 32'h1);
    chk(viol_flag == 1'b1, "R9 flag held", {31'b0, viol_flag}, 32'h1);

    // R7 same-edge denied write and violation update
    xfer(1'b1, 8'h08, 32'h7777, 3'b001, 3'd2, 1'b0, 3'b0, 3'd0);
    chk(r_err == 1'b1 && r_data == 32'h0, "R7 deny wr", {31'b0, r_err}, 32'h1);
    chk(viol_id == 3'd2, "R9 id wr", {29'b0, viol_id}, 32'h2);
    xfer(1'b0, 8'h08, 32'h0, 3'b000, 3'd0, 1'b0, 3'b0, 3'd0);
    chk(r_data == 32'h006E, "R7 reg kept", r_data, 32'h006E);

    // R1 mid-run reset restores defaults and clears the record
    rst_n = 1'b0;
    #1;
    chk(viol_flag == 1'b0, "R1 async flag", {31'b0, viol_flag}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    xfer(1'b0, 8'h00, 32'h0, 3'b000, 3'd0, 1'b0, 3'b0, 3'd0);
    chk(r_data == 32'h0050, "R1 reg0 default", r_data, 32'h0050);
    xfer(1'b0, 8'h08, 32'h0, 3'b000, 3'd0, 1'b0, 3'b0, 3'd0);
    chk(r_data == 32'h0069, "R1 reg2 default", r_data, 32'h0069);
    chk(viol_id == 3'd0, "R1 id cleared", {29'b0, viol_id}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule